// File: doc/BRIEF.md
# Dual Serial-Port Word Queues with Level Requests

This block holds two small word queues for a serial port. The receive queue is filled by the receiver and emptied by the host. The transmit queue is filled by the host and emptied by the transmitter. Each queue stores words of up to 9 bits and reports its occupancy as a count. Each queue also has a 2-bit programmable threshold that drives a data-request level. The receive request looks at filled slots and the transmit request looks at free slots, so a DMA engine or an interrupt can react before the queue runs dry or fills up.

Each queue has a flush input and a sticky error flag. The error flag records a write to a full queue or a read from an empty one. The block also keeps a "shift register holds data" flag for each direction. A flush clears that flag, except on the transmit side when the transmission of the held word has already begun.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset, both counts are 0, both error flags are 0, both shift-holding flags are 0, `rx_req` is 0 and `tx_req` is 1.
- R2: Each queue is first-in first-out and keeps all 9 bits of each word. An accepted push raises the count by one at the next clock edge. An accepted pop lowers it by one, and the popped word appears on the read-data port after that same edge and is held until the next accepted pop.
- R3: `rx_req` is 1 exactly when the receive count is at least the threshold code plus one (codes 0..3 mean 1..4 filled slots). It follows the count combinationally.
- R4: `tx_req` is 1 exactly when the free slots (4 minus the transmit count) are at least the threshold code plus one (codes 0..3 mean 1..4 free slots).
- R5: A flush sets the count to 0 at the next edge. A push or pop in the same cycle is ignored and raises no error.
- R6: `rx_sr_full` is set by `rx_sr_set` and cleared by `rx_push`. A set in the same cycle as a push wins. `rx_flush` always clears it, and the flush wins over a set.
- R7: `tx_sr_full` is set by an accepted transmit pop and cleared by `tx_sr_done`. A `tx_sr_start` pulse while the flag is set marks the transmission as begun. `tx_flush` clears the flag only if the transmission has not begun.
- R8: A push while the count is 4 is rejected, even when a pop comes in the same cycle. It sets the error flag and leaves the stored words unchanged.
- R9: A pop while the count is 0 sets the error flag and leaves the read-data port unchanged.
- R10: The error flag stays set until its clear input is pulsed. A new error in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_push | input | 1 | Receiver writes a word |
| rx_wdata | input | 9 | Word from the receiver |
| rx_pop | input | 1 | Host reads a word |
| rx_rdata | output | 9 | Last word read by the host |
| rx_count | output | 3 | Receive occupancy |
| rx_thresh | input | 2 | Receive request threshold code |
| rx_req | output | 1 | Receive data request |
| rx_flush | input | 1 | Empty the receive queue and the held receive data |
| rx_err | output | 1 | Sticky receive queue error |
| rx_err_clr | input | 1 | Clear receive error |
| rx_sr_set | input | 1 | Receiver shift register now holds a word |
| rx_sr_full | output | 1 | Receive shift register holds data |
| tx_push | input | 1 | Host writes a word |
| tx_wdata | input | 9 | Word from the host |
| tx_pop | input | 1 | Transmitter takes a word |
| tx_rdata | output | 9 | Last word taken by the transmitter |
| tx_count | output | 3 | Transmit occupancy |
| tx_thresh | input | 2 | Transmit request threshold code |
| tx_req | output | 1 | Transmit data request |
| tx_flush | input | 1 | Empty the transmit queue |
| tx_err | output | 1 | Sticky transmit queue error |
| tx_err_clr | input | 1 | Clear transmit error |
| tx_sr_start | input | 1 | Transmitter began sending the held word |
| tx_sr_done | input | 1 | Transmitter finished the held word |
| tx_sr_full | output | 1 | Transmit shift register holds data |

## Verification
The bench sweeps every threshold code against every count on both queues. A design that compared free slots on the receive side, or was off by one, would give a wrong request level at the 1 or 4 boundary. It pushes into a full queue with and without a simultaneous pop, and pops an empty queue. A design that let the rejected word overwrite a slot, or changed the read data on a failed pop, would show wrong words on the later drain. It also flushes together with a push, and flushes the transmit holding flag before and after the start of a transmission. A design that let the push through, or cleared a word already on the wire, would leave a nonzero count or a dropped flag.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int unsigned WORD_W = 9;
  localparam int unsigned QDEPTH = 4;
  typedef enum logic {REQ_ON_FILLED, REQ_ON_EMPTY} req_mode_e;
endpackage

// File: rtl/fifo_core.sv
module fifo_core #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 9,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  input  logic             flush,
  input  logic             err_clr,
  output logic [WIDTH-1:0] rdata,
  output logic [CNT_W-1:0] count,
  output logic             err,
  output logic             pop_ok
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic full, empty, push_ok, bad;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign bad     = !flush && ((push && full) || (pop && empty));

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (pop_ok) begin
      rdata <= mem[rd_ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          err <= 1'b0;
    else if (bad)     err <= 1'b1;
    else if (err_clr) err <= 1'b0;
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH)); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> count == '0); // R5
  AST_FULL_PUSH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> (count == $past(count)) && err); // R8
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !flush) |=> $stable(rdata) && err); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err && !err_clr) |=> err); // R10
endmodule

// File: rtl/fifo_req.sv
module fifo_req
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter req_mode_e   MODE  = REQ_ON_FILLED,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned TH_W  = $clog2(DEPTH)
) (
  input  logic [CNT_W-1:0] count,
  input  logic [TH_W-1:0]  thresh,
  output logic             req
);
  logic [CNT_W-1:0] level;
  logic [CNT_W-1:0] need;

  generate
    if (MODE == REQ_ON_FILLED) begin : g_filled
      assign level = count;
    end else begin : g_empty
      assign level = CNT_W'(DEPTH) - count;
    end
  endgenerate

  assign need = CNT_W'(thresh) + 1'b1;
  assign req  = (level >= need);
endmodule

// File: rtl/shreg_track.sv
module shreg_track #(
  parameter bit HAS_START = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic start,
  input  logic done,
  input  logic flush,
  output logic full
);
  logic started;
  logic flush_clr;

  generate
    if (HAS_START) begin : g_start
      always_ff @(posedge clk) begin
        if (rst)                    started <= 1'b0;
        else if (done || !full)     started <= 1'b0;
        else if (start)             started <= 1'b1;
      end
    end else begin : g_nostart
      assign started = 1'b0;
    end
  endgenerate

  assign flush_clr = flush && !started;

  always_ff @(posedge clk) begin
    if (rst)            full <= 1'b0;
    else if (flush_clr) full <= 1'b0;
    else if (load)      full <= 1'b1;
    else if (done)      full <= 1'b0;
  end

  AST_FLUSH_CLEARS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flush && !HAS_START) |=> !full); // R6
  AST_LOAD_SETS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (load && !flush) |=> full); // R7
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = QDEPTH,
  parameter int unsigned WIDTH = WORD_W,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned TH_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_push,
  input  logic [WIDTH-1:0] rx_wdata,
  input  logic             rx_pop,
  output logic [WIDTH-1:0] rx_rdata,
  output logic [CNT_W-1:0] rx_count,
  input  logic [TH_W-1:0]  rx_thresh,
  output logic             rx_req,
  input  logic             rx_flush,
  output logic             rx_err,
  input  logic             rx_err_clr,
  input  logic             rx_sr_set,
  output logic             rx_sr_full,
  input  logic             tx_push,
  input  logic [WIDTH-1:0] tx_wdata,
  input  logic             tx_pop,
  output logic [WIDTH-1:0] tx_rdata,
  output logic [CNT_W-1:0] tx_count,
  input  logic [TH_W-1:0]  tx_thresh,
  output logic             tx_req,
  input  logic             tx_flush,
  output logic             tx_err,
  input  logic             tx_err_clr,
  input  logic             tx_sr_start,
  input  logic             tx_sr_done,
  output logic             tx_sr_full
);
  logic rx_pop_ok, tx_pop_ok;

  fifo_core #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
    .flush(rx_flush), .err_clr(rx_err_clr), .rdata(rx_rdata),
    .count(rx_count), .err(rx_err), .pop_ok(rx_pop_ok));

  fifo_core #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
    .flush(tx_flush), .err_clr(tx_err_clr), .rdata(tx_rdata),
    .count(tx_count), .err(tx_err), .pop_ok(tx_pop_ok));

  fifo_req #(.DEPTH(DEPTH), .MODE(REQ_ON_FILLED)) u_rxreq (
    .count(rx_count), .thresh(rx_thresh), .req(rx_req));

  fifo_req #(.DEPTH(DEPTH), .MODE(REQ_ON_EMPTY)) u_txreq (
    .count(tx_count), .thresh(tx_thresh), .req(tx_req));

  shreg_track #(.HAS_START(1'b0)) u_rxsr (
    .clk(clk), .rst(rst), .load(rx_sr_set), .start(1'b0), .done(rx_push),
    .flush(rx_flush), .full(rx_sr_full));

  shreg_track #(.HAS_START(1'b1)) u_txsr (
    .clk(clk), .rst(rst), .load(tx_pop_ok), .start(tx_sr_start), .done(tx_sr_done),
    .flush(tx_flush), .full(tx_sr_full));

  AST_RX_UNUSED_POP: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && !rx_pop_ok) |=> $stable(rx_rdata)); // R9
endmodule

// File: tb/tb_uart_fifo_pair.sv
module tb_uart_fifo_pair;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_push = 0, rx_pop = 0, rx_flush = 0, rx_err_clr = 0, rx_sr_set = 0;
  logic tx_push = 0, tx_pop = 0, tx_flush = 0, tx_err_clr = 0, tx_sr_start = 0, tx_sr_done = 0;
  logic [8:0] rx_wdata = '0, tx_wdata = '0;
  logic [1:0] rx_thresh = '0, tx_thresh = '0;
  logic [8:0] rx_rdata, tx_rdata;
  logic [2:0] rx_count, tx_count;
  logic rx_req, tx_req, rx_err, tx_err, rx_sr_full, tx_sr_full;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  uart_fifo_pair dut (
    .clk(clk), .rst(rst),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .rx_count(rx_count), .rx_thresh(rx_thresh), .rx_req(rx_req), .rx_flush(rx_flush),
    .rx_err(rx_err), .rx_err_clr(rx_err_clr), .rx_sr_set(rx_sr_set), .rx_sr_full(rx_sr_full),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .tx_count(tx_count), .tx_thresh(tx_thresh), .tx_req(tx_req), .tx_flush(tx_flush),
    .tx_err(tx_err), .tx_err_clr(tx_err_clr), .tx_sr_start(tx_sr_start),
    .tx_sr_done(tx_sr_done), .tx_sr_full(tx_sr_full));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock edge; pulse inputs are released after it
  task automatic cyc();
    @(negedge clk);
    rx_push = 0; rx_pop = 0; rx_flush = 0; rx_err_clr = 0; rx_sr_set = 0;
    tx_push = 0; tx_pop = 0; tx_flush = 0; tx_err_clr = 0; tx_sr_start = 0; tx_sr_done = 0;
  endtask

  task automatic rx_put(input logic [8:0] w);
    rx_push = 1; rx_wdata = w; cyc();
  endtask

  task automatic tx_put(input logic [8:0] w);
    tx_push = 1; tx_wdata = w; cyc();
  endtask

  task automatic t_reset();
    chk("R1 rx_count", rx_count, 0);
    chk("R1 tx_count", tx_count, 0);
    chk("R1 errs", {rx_err, tx_err}, 0);
    chk("R1 sr flags", {rx_sr_full, tx_sr_full}, 0);
    chk("R1 rx_req", rx_req, 0);
    chk("R1 tx_req", tx_req, 1);
  endtask

  task automatic t_order();
    rx_put(9'h1FF); chk("R2 count up", rx_count, 1);
    rx_put(9'h0A5); rx_put(9'h100);
    chk("R2 count 3", rx_count, 3);
    rx_pop = 1; cyc(); chk("R2 first word", rx_rdata, 9'h1FF); chk("R2 count down", rx_count, 2);
    cyc(); chk("R2 rdata held", rx_rdata, 9'h1FF);
    rx_pop = 1; cyc(); chk("R2 second word", rx_rdata, 9'h0A5);
    rx_pop = 1; cyc(); chk("R2 bit 8 kept", rx_rdata, 9'h100);
    chk("R2 drained", rx_count, 0);
  endtask

  task automatic t_rx_thresh();
    for (int c = 0; c <= 4; c++) begin
      for (int t = 0; t < 4; t++) begin
        rx_thresh = 2'(t); #1;
        chk("R3 rx_req level", rx_req, (c >= t + 1) ? 1 : 0);
      end
      if (c < 4) rx_put(9'(c));
    end
    rx_flush = 1; cyc(); rx_thresh = 0;
  endtask

  task automatic t_tx_thresh();
    for (int c = 0; c <= 4; c++) begin
      for (int t = 0; t < 4; t++) begin
        tx_thresh = 2'(t); #1;
        chk("R4 tx_req level", tx_req, ((4 - c) >= t + 1) ? 1 : 0);
      end
      if (c < 4) tx_put(9'(c + 8));
    end
    tx_flush = 1; cyc(); tx_thresh = 0;
  endtask

  task automatic t_overflow();
    rx_put(9'h011); rx_put(9'h022); rx_put(9'h033); rx_put(9'h044);
    rx_put(9'h155);
    chk("R8 count stays 4", rx_count, 4);
    chk("R8 err set", rx_err, 1);
    rx_push = 1; rx_wdata = 9'h166; rx_pop = 1; cyc();
    chk("R8 push+pop on full", rx_count, 3);
    chk("R8 popped head", rx_rdata, 9'h011);
    rx_pop = 1; cyc(); chk("R8 contents intact 2", rx_rdata, 9'h022);
    rx_pop = 1; cyc(); chk("R8 contents intact 3", rx_rdata, 9'h033);
    rx_pop = 1; cyc(); chk("R8 contents intact 4", rx_rdata, 9'h044);
    chk("R8 empty after drain", rx_count, 0);
    rx_err_clr = 1; cyc();
  endtask

  task automatic t_underflow();
    rx_pop = 1; cyc();
    chk("R9 err set", rx_err, 1);
    chk("R9 rdata unchanged", rx_rdata, 9'h044);
    chk("R9 count 0", rx_count, 0);
    tx_pop = 1; cyc();
    chk("R9 tx err set", tx_err, 1);
  endtask

  task automatic t_sticky();
    cyc(); cyc();
    chk("R10 rx err holds", rx_err, 1);
    rx_err_clr = 1; cyc();
    chk("R10 rx err cleared", rx_err, 0);
    tx_err_clr = 1; tx_pop = 1; cyc();
    chk("R10 set beats clear", tx_err, 1);
    tx_err_clr = 1; cyc();
    chk("R10 tx err cleared", tx_err, 0);
  endtask

  task automatic t_flush();
    rx_put(9'h001); rx_put(9'h002); rx_put(9'h003);
    rx_flush = 1; rx_push = 1; rx_wdata = 9'h0FF; rx_pop = 1; cyc();
    chk("R5 flush empties", rx_count, 0);
    chk("R5 no error", rx_err, 0);
    chk("R5 rdata not popped", rx_rdata, 9'h044);
    rx_put(9'h077); rx_pop = 1; cyc();
    chk("R5 clean after flush", rx_rdata, 9'h077);
  endtask

  task automatic t_rx_sr();
    rx_sr_set = 1; cyc(); chk("R6 set", rx_sr_full, 1);
    rx_push = 1; rx_wdata = 9'h012; cyc(); chk("R6 push clears", rx_sr_full, 0);
    rx_sr_set = 1; rx_push = 1; cyc(); chk("R6 set beats push", rx_sr_full, 1);
    rx_flush = 1; cyc(); chk("R6 flush clears", rx_sr_full, 0);
    rx_sr_set = 1; rx_flush = 1; cyc(); chk("R6 flush beats set", rx_sr_full, 0);
  endtask

  task automatic t_tx_sr();
    tx_put(9'h1A1); tx_pop = 1; cyc();
    chk("R7 pop loads", tx_sr_full, 1);
    chk("R7 word out", tx_rdata, 9'h1A1);
    tx_flush = 1; cyc(); chk("R7 flush before start", tx_sr_full, 0);
    tx_put(9'h0B2); tx_pop = 1; cyc();
    tx_sr_start = 1; cyc();
    tx_flush = 1; cyc(); chk("R7 flush after start", tx_sr_full, 1);
    tx_sr_done = 1; cyc(); chk("R7 done clears", tx_sr_full, 0);
  endtask

  initial begin
    cyc(); cyc(); rst = 0; cyc();
    t_reset();
    t_order();
    t_rx_thresh();
    t_tx_thresh();
    t_overflow();
    t_underflow();
    t_sticky();
    t_flush();
    t_rx_sr();
    t_tx_sr();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule